// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the timing for a parallel RGB LCD panel from a single main clock. An integer divider derives the pixel clock. A polarity bit selects whether the rising or the falling pixel clock edge is the one the panel samples on. A horizontal counter and a vertical counter walk the raster and generate HSYNC, VSYNC and a data-enable window. Each axis is set by five fields: a total length, the start of the visible area, the visible length, and two sync points. The sync line stays at its idle high level from the start of the line or frame until the first point, goes low there, and returns high at the second point.

Pixel data arrives as 8-bit red, green and blue values. The block latches them on each pixel step and forwards the upper six bits of each channel to the panel. An optional colour-skew mode shows red one pixel period ahead of green and blue one pixel period behind it, so the three channel buses do not all switch at the same instant. A divider value of zero turns the panel off. All settings, including the divider, polarity and skew, are copied into shadow registers at the start of every frame, so a mid-frame write only takes effect at the next frame.

Top module: `lcd_raster_gen`

## Requirements
- R1: While the internal reset is active, and on every main clock edge at which `cfg_div` is zero, the outputs go to the idle state: `pclk_o`=0, `hsync_o`=1, `vsync_o`=1, `de_o`=0, and `r_o`, `g_o`, `b_o` all zero. Pixel inputs have no effect while the block is idle.
- R2: Let E0 be the main clock edge at which `cfg_div` first becomes a nonzero value D with polarity P. After edge E0+n, `pclk_o` equals P xor ((n mod D) >= floor(D/2)).
- R3: After E0, the sync, enable and colour outputs change only at edges E0+n where n is a nonzero multiple of D. These edges are pixel steps, and step t happens at n = t*D.
- R4: Pixel position p has column h = p mod HTOTAL and line v = floor(p / HTOTAL) mod VTOTAL, counting from position 0 at E0. After step t, the green channel, `hsync_o`, `vsync_o` and `de_o` show position t-2. Before step 2 they hold the idle values.
- R5: `de_o` is 1 for a position only when hstart <= h < hstart+hlen and vstart <= v < vstart+vlen.
- R6: `hsync_o` is 0 for a position only when hsync_b > hsync_a and hsync_a <= h < hsync_b. In every other case it is 1, so it stays high for the whole line when hsync_b <= hsync_a.
- R7: `vsync_o` follows the R6 rule using the line index v and the vertical sync points.
- R8: Each colour output carries bits [7:2] of the matching pixel input, sampled at the pixel step that captures its position. A channel is zero when its own position lies outside the visible window.
- R9: With the skew bit at 0, red and blue show the same position as green. With it at 1, red shows position t-1 and blue shows position t-3 after step t, and a negative position reads as zero.
- R10: All configuration inputs are copied into shadow registers at E0 and at the pixel step that captures the last position of a frame. Writes at any other time affect only later frames.
- R11: When `cfg_div` returns to zero and later becomes nonzero again, the raster restarts at position 0 and the R2 and R4 timing is counted from the new E0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_div | input | DIV_W | Pixel clock divisor; zero turns the panel off |
| cfg_pclk_inv | input | 1 | 0: rising pixel clock edge active, 1: falling edge active |
| cfg_spread | input | 1 | Colour-skew enable |
| cfg_h_total | input | 12 | Pixel clocks per line |
| cfg_h_start | input | 12 | First visible column |
| cfg_h_width | input | 12 | Visible columns |
| cfg_h_sync_a | input | 12 | Column where HSYNC goes low |
| cfg_h_sync_b | input | 12 | Column where HSYNC returns high |
| cfg_v_total | input | 12 | Lines per frame |
| cfg_v_start | input | 12 | First visible line |
| cfg_v_height | input | 12 | Visible lines |
| cfg_v_sync_a | input | 12 | Line where VSYNC goes low |
| cfg_v_sync_b | input | 12 | Line where VSYNC returns high |
| pix_r | input | 8 | Red pixel data |
| pix_g | input | 8 | Green pixel data |
| pix_b | input | 8 | Blue pixel data |
| pclk_o | output | 1 | Pixel clock to the panel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| r_o | output | 6 | Red bits [7:2] |
| g_o | output | 6 | Green bits [7:2] |
| b_o | output | 6 | Blue bits [7:2] |

## Verification
The raster is swept over a 10-by-6 frame with divisors of 1, 2, 3, 4 and 5. This covers a divisor of 1, where the pixel clock is constant, and even and odd divisors, where the two clock phases have different lengths. Every main clock cycle is checked against arithmetic expectations. A visible window and sync interval placed inside the line are set against a window that spans the full frame and against sync points with b <= a, which separates correct window edges from off-by-one edges and exercises the idle-level rule. Three more cases are run. Skew on and off at the same position tells the channel delays apart. A window change written partway into a frame shows whether the shadow load waits for the frame boundary. A disable and re-enable partway into a frame shows whether the counters restart from zero.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  localparam int unsigned LCD_AXIS_W = 12;
  localparam int unsigned LCD_CIN_W  = 8;
  localparam int unsigned LCD_COUT_W = 6;

  typedef logic [LCD_AXIS_W-1:0] axis_t;
  typedef logic [LCD_COUT_W-1:0] cout_t;

  typedef struct packed {
    axis_t total;
    axis_t start;
    axis_t len;
    axis_t sync_a;
    axis_t sync_b;
  } axis_cfg_t;

  typedef struct packed {
    logic  hs;
    logic  vs;
    logic  de;
    cout_t r;
    cout_t g;
    cout_t b;
  } pix_stage_t;

  localparam pix_stage_t PIX_IDLE = '{hs: 1'b1, vs: 1'b1, de: 1'b0,
                                      r: '0, g: '0, b: '0};
endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic             clear,
  input  logic [DIV_W-1:0] div_cur,
  input  logic [DIV_W-1:0] div_nxt,
  input  logic             pol_nxt,
  output logic             tick,
  output logic             pclk
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             pclk_q, pclk_d;

  // one pixel step every div_cur main clocks
  assign tick = run & ~clear & (cnt_q >= (div_cur - DIV_W'(1)));

  always_comb begin
    if (clear || tick) cnt_d = '0;
    else               cnt_d = cnt_q + DIV_W'(1);
    pclk_d = en & (pol_nxt ^ (cnt_d >= (div_nxt >> 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pclk_q <= pclk_d;
    end
  end

  assign pclk = pclk_q;
endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr
  import lcd_raster_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      step,
  input  axis_cfg_t cfg,
  output axis_t     cnt,
  output logic      last,
  output logic      vis,
  output logic      sync
);
  localparam int unsigned AW = LCD_AXIS_W;

  axis_t         cnt_q, cnt_d;
  logic [AW:0]   cnt_inc, win_end;

  assign cnt_inc = {1'b0, cnt_q} + (AW+1)'(1);
  assign win_end = {1'b0, cfg.start} + {1'b0, cfg.len};
  assign last    = cnt_inc >= {1'b0, cfg.total};
  assign vis     = (cnt_q >= cfg.start) && ({1'b0, cnt_q} < win_end);
  assign sync    = !((cfg.sync_b > cfg.sync_a) &&
                     (cnt_q >= cfg.sync_a) && (cnt_q < cfg.sync_b));

  always_comb begin
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = last ? '0 : cnt_inc[AW-1:0];
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lcd_color_pipe.sv
module lcd_color_pipe
  import lcd_raster_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       tick,
  input  logic       spread,
  input  pix_stage_t stage_in,
  output pix_stage_t stage_out
);
  pix_stage_t s1_q, s1_d, s2_q, s2_d;
  cout_t      b3_q, b3_d;

  always_comb begin
    s1_d = s1_q;
    s2_d = s2_q;
    b3_d = b3_q;
    if (clear) begin
      s1_d = PIX_IDLE;
      s2_d = PIX_IDLE;
      b3_d = '0;
    end else if (tick) begin
      s1_d = stage_in;
      s2_d = s1_q;
      b3_d = s2_q.b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= PIX_IDLE;
      s2_q <= PIX_IDLE;
      b3_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      b3_q <= b3_d;
    end
  end

  // green and timing from the middle stage, red one ahead, blue one behind
  always_comb begin
    stage_out   = s2_q;
    stage_out.r = spread ? s1_q.r : s2_q.r;
    stage_out.b = spread ? b3_q   : s2_q.b;
  end
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      cfg_div,
  input  logic                  cfg_pclk_inv,
  input  logic                  cfg_spread,
  input  logic [LCD_AXIS_W-1:0] cfg_h_total,
  input  logic [LCD_AXIS_W-1:0] cfg_h_start,
  input  logic [LCD_AXIS_W-1:0] cfg_h_width,
  input  logic [LCD_AXIS_W-1:0] cfg_h_sync_a,
  input  logic [LCD_AXIS_W-1:0] cfg_h_sync_b,
  input  logic [LCD_AXIS_W-1:0] cfg_v_total,
  input  logic [LCD_AXIS_W-1:0] cfg_v_start,
  input  logic [LCD_AXIS_W-1:0] cfg_v_height,
  input  logic [LCD_AXIS_W-1:0] cfg_v_sync_a,
  input  logic [LCD_AXIS_W-1:0] cfg_v_sync_b,
  input  logic [LCD_CIN_W-1:0]  pix_r,
  input  logic [LCD_CIN_W-1:0]  pix_g,
  input  logic [LCD_CIN_W-1:0]  pix_b,
  output logic                  pclk_o,
  output logic                  hsync_o,
  output logic                  vsync_o,
  output logic                  de_o,
  output logic [LCD_COUT_W-1:0] r_o,
  output logic [LCD_COUT_W-1:0] g_o,
  output logic [LCD_COUT_W-1:0] b_o
);
  localparam int unsigned CHI = LCD_CIN_W - 1;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic en_live, run_q, rise, clear, tick, load, frame_end;
  assign en_live = |cfg_div;
  assign rise    = en_live & ~run_q;
  assign clear   = ~en_live | rise;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= 1'b0;
    else             run_q <= en_live;
  end

  // frame-start shadow registers
  logic [DIV_W-1:0] div_sh, div_nxt;
  logic             pol_sh, pol_nxt, spread_sh, spread_nxt;
  axis_cfg_t        h_sh, h_nxt, v_sh, v_nxt, h_live, v_live;

  assign h_live = '{total: cfg_h_total, start: cfg_h_start, len: cfg_h_width,
                    sync_a: cfg_h_sync_a, sync_b: cfg_h_sync_b};
  assign v_live = '{total: cfg_v_total, start: cfg_v_start, len: cfg_v_height,
                    sync_a: cfg_v_sync_a, sync_b: cfg_v_sync_b};

  always_comb begin
    div_nxt    = load ? cfg_div      : div_sh;
    pol_nxt    = load ? cfg_pclk_inv : pol_sh;
    spread_nxt = load ? cfg_spread   : spread_sh;
    h_nxt      = load ? h_live       : h_sh;
    v_nxt      = load ? v_live       : v_sh;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_sh    <= '0;
      pol_sh    <= 1'b0;
      spread_sh <= 1'b0;
      h_sh      <= '0;
      v_sh      <= '0;
    end else begin
      div_sh    <= div_nxt;
      pol_sh    <= pol_nxt;
      spread_sh <= spread_nxt;
      h_sh      <= h_nxt;
      v_sh      <= v_nxt;
    end
  end

  lcd_pclk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run_q),
    .en      (en_live),
    .clear   (clear),
    .div_cur (div_sh),
    .div_nxt (div_nxt),
    .pol_nxt (pol_nxt),
    .tick    (tick),
    .pclk    (pclk_o)
  );

  axis_t h_cnt, v_cnt, h_total_q;
  logic  h_last, h_vis, h_sync, v_last, v_vis, v_sync;

  lcd_axis_ctr u_hax (
    .clk (clk), .rst_n (rst_sync_n), .clear (clear), .step (tick),
    .cfg (h_sh), .cnt (h_cnt), .last (h_last), .vis (h_vis), .sync (h_sync)
  );

  lcd_axis_ctr u_vax (
    .clk (clk), .rst_n (rst_sync_n), .clear (clear), .step (tick & h_last),
    .cfg (v_sh), .cnt (v_cnt), .last (v_last), .vis (v_vis), .sync (v_sync)
  );

  assign h_total_q = h_sh.total;
  assign frame_end = tick & h_last & v_last;
  assign load      = rise | frame_end;

  pix_stage_t stage_in, stage_out;
  always_comb begin
    stage_in.hs = h_sync;
    stage_in.vs = v_sync;
    stage_in.de = h_vis & v_vis;
    stage_in.r  = stage_in.de ? pix_r[CHI -: LCD_COUT_W] : '0;
    stage_in.g  = stage_in.de ? pix_g[CHI -: LCD_COUT_W] : '0;
    stage_in.b  = stage_in.de ? pix_b[CHI -: LCD_COUT_W] : '0;
  end

  lcd_color_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear     (clear),
    .tick      (tick),
    .spread    (spread_sh),
    .stage_in  (stage_in),
    .stage_out (stage_out)
  );

  assign hsync_o = stage_out.hs;
  assign vsync_o = stage_out.vs;
  assign de_o    = stage_out.de;
  assign r_o     = stage_out.r;
  assign g_o     = stage_out.g;
  assign b_o     = stage_out.b;
endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk
  import lcd_raster_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] cfg_div,
  input logic             run_q,
  input logic             tick,
  input axis_t            h_cnt,
  input axis_t            v_cnt,
  input axis_t            h_total_q,
  input logic             pclk_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             de_o,
  input cout_t            r_o,
  input cout_t            g_o,
  input cout_t            b_o
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div == '0) |=> (!pclk_o && hsync_o && vsync_o && !de_o &&
                         r_o == '0 && g_o == '0 && b_o == '0)); // R1

  AST_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && cfg_div != '0) |=>
      $stable({hsync_o, vsync_o, de_o, r_o, g_o, b_o})); // R3

  AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && h_total_q != '0) |-> (h_cnt < h_total_q)); // R4

  AST_DARK_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> (g_o == '0)); // R8

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (h_cnt == '0 && v_cnt == '0)); // R11
endmodule

bind lcd_raster_gen lcd_raster_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_div   (cfg_div),
  .run_q     (run_q),
  .tick      (tick),
  .h_cnt     (h_cnt),
  .v_cnt     (v_cnt),
  .h_total_q (h_total_q),
  .pclk_o    (pclk_o),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .de_o      (de_o),
  .r_o       (r_o),
  .g_o       (g_o),
  .b_o       (b_o)
);

// File: tb/lcd_raster_gen_bench.sv
module lcd_raster_gen_bench;
  import lcd_raster_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [7:0]  cfg_div;
  logic        cfg_pclk_inv, cfg_spread;
  axis_t       h_total, h_start, h_width, h_sa, h_sb;
  axis_t       v_total, v_start, v_height, v_sa, v_sb;
  logic [7:0]  pix_r, pix_g, pix_b;
  logic        pclk_o, hsync_o, vsync_o, de_o;
  logic [5:0]  r_o, g_o, b_o;

  lcd_raster_gen u_lcd_raster_gen (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_pclk_inv(cfg_pclk_inv),
    .cfg_spread(cfg_spread),
    .cfg_h_total(h_total), .cfg_h_start(h_start), .cfg_h_width(h_width),
    .cfg_h_sync_a(h_sa), .cfg_h_sync_b(h_sb),
    .cfg_v_total(v_total), .cfg_v_start(v_start), .cfg_v_height(v_height),
    .cfg_v_sync_a(v_sa), .cfg_v_sync_b(v_sb),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .r_o(r_o), .g_o(g_o), .b_o(b_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // index: 0 htotal 1 hstart 2 hwidth 3 hsa 4 hsb 5 vtotal 6 vstart 7 vheight 8 vsa 9 vsb
  int lo[10];
  int hi[10];
  int set_a[10] = '{10, 2, 5, 1, 3, 6, 1, 3, 0, 2};
  int set_b[10] = '{10, 4, 6, 5, 9, 6, 2, 4, 3, 3};
  int set_c[10] = '{10, 0, 10, 4, 2, 6, 0, 6, 2, 5};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply_cfg(int c[10]);
    h_total = axis_t'(c[0]); h_start = axis_t'(c[1]); h_width = axis_t'(c[2]);
    h_sa = axis_t'(c[3]); h_sb = axis_t'(c[4]);
    v_total = axis_t'(c[5]); v_start = axis_t'(c[6]); v_height = axis_t'(c[7]);
    v_sa = axis_t'(c[8]); v_sb = axis_t'(c[9]);
  endtask

  function automatic int pv(int p, int ch);
    if (ch == 0) return (p * 7 + 3) & 255;
    if (ch == 1) return (p * 13 + 100) & 255;
    return (p * 29 + 55) & 255;
  endfunction

  function automatic int cf(int p, int idx);
    if (p / (lo[0] * lo[5]) == 0) return lo[idx];
    return hi[idx];
  endfunction

  function automatic int ph(int p); return p % lo[0]; endfunction
  function automatic int pvl(int p); return (p / lo[0]) % lo[5]; endfunction

  function automatic int e_de(int p);
    int h, v;
    if (p < 0) return 0;
    h = ph(p); v = pvl(p);
    return int'(h >= cf(p, 1) && h < cf(p, 1) + cf(p, 2) &&
                v >= cf(p, 6) && v < cf(p, 6) + cf(p, 7));
  endfunction

  function automatic int e_sync(int p, int cnt, int ia, int ib);
    if (p < 0) return 1;
    return int'(!(cf(p, ib) > cf(p, ia) && cnt >= cf(p, ia) && cnt < cf(p, ib)));
  endfunction

  function automatic int e_col(int p, int ch);
    if (p < 0 || e_de(p) == 0) return 0;
    return pv(p, ch) >> 2;
  endfunction

  task automatic idle_chk(string tag);
    chk({tag, " pclk"}, int'(pclk_o), 0);
    chk({tag, " hsync"}, int'(hsync_o), 1);
    chk({tag, " vsync"}, int'(vsync_o), 1);
    chk({tag, " de"}, int'(de_o), 0);
    chk({tag, " rgb"}, int'({r_o, g_o, b_o}), 0);
  endtask

  task automatic idle_phase(int cycles);
    cfg_div = 8'd0;
    @(posedge clk);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      idle_chk("R1 idle");
      pix_r = 8'(i * 11 + 200); pix_g = 8'(i * 5 + 1); pix_b = 8'hFF;
    end
  endtask

  // starts at a negedge, returns at a negedge
  task automatic run_seg(int d, int pol, int spr, int nt, int chg_t, string tag);
    int t, q, qr, qb;
    logic [21:0] prev_obs, obs;
    apply_cfg(lo);
    cfg_pclk_inv = pol[0]; cfg_spread = spr[0];
    pix_r = 8'(pv(0, 0)); pix_g = 8'(pv(0, 1)); pix_b = 8'(pv(0, 2));
    cfg_div = 8'(d);
    @(posedge clk);
    prev_obs = '0;
    for (int n = 0; n <= nt * d; n++) begin
      @(negedge clk);
      t = n / d;
      if (chg_t >= 0 && t == chg_t) apply_cfg(hi);
      obs = {pclk_o, hsync_o, vsync_o, de_o, r_o, g_o, b_o};
      chk({tag, " R2 pclk"}, int'(pclk_o), pol ^ int'((n % d) >= d / 2));
      if (n >= 1 && (n % d) != 0)
        chk({tag, " R3 hold between steps"}, int'(obs[20:0]), int'(prev_obs[20:0]));
      q  = t - 2;
      qr = spr ? t - 1 : q;
      qb = spr ? t - 3 : q;
      chk({tag, " R4 R6 hsync"}, int'(hsync_o), e_sync(q, q < 0 ? 0 : ph(q), 3, 4));
      chk({tag, " R7 vsync"}, int'(vsync_o), e_sync(q, q < 0 ? 0 : pvl(q), 8, 9));
      chk({tag, " R5 de"}, int'(de_o), e_de(q));
      chk({tag, " R8 green"}, int'(g_o), e_col(q, 1));
      chk({tag, " R9 red"}, int'(r_o), e_col(qr, 0));
      chk({tag, " R9 blue"}, int'(b_o), e_col(qb, 2));
      prev_obs = obs;
      pix_r = 8'(pv(t, 0)); pix_g = 8'(pv(t, 1)); pix_b = 8'(pv(t, 2));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_div = 8'd0; cfg_pclk_inv = 1'b1; cfg_spread = 1'b1;
    pix_r = 8'hFF; pix_g = 8'hFF; pix_b = 8'hFF;
    lo = set_a; hi = set_a;
    apply_cfg(lo);
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_chk("R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_chk("R1 after reset");
    idle_phase(8);

    // R4 R5 R6 R7 R8: divisor 1, no skew
    @(negedge clk);
    lo = set_a; hi = set_a;
    run_seg(1, 0, 0, 130, -1, "A d1");
    idle_phase(5);

    // R9 R10: odd divisor, inverted clock, skew, window change mid-frame
    @(negedge clk);
    lo = set_a; hi = set_b;
    run_seg(3, 1, 1, 140, 20, "R10 d3");
    idle_phase(5);

    // R6 R7 degenerate sync, full window, even divisor
    @(negedge clk);
    lo = set_c; hi = set_c;
    run_seg(4, 0, 1, 130, -1, "C d4");
    idle_phase(5);

    // R11: stop mid-frame and restart
    @(negedge clk);
    lo = set_a; hi = set_a;
    run_seg(2, 1, 0, 37, -1, "R11 first");
    idle_phase(6);
    @(negedge clk);
    run_seg(5, 0, 0, 70, -1, "R11 restart");
    idle_phase(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule